// File: doc/BRIEF.md
# UART Receive Hunt Controller

This block sits between a UART character deserialiser and the receive buffer logic. It owns a hunt state that gates the character stream. While hunting, incoming characters are thrown away until a resynchronisation event chosen by `mode_addr_i` occurs. In idle mode that event is one complete idle character time on the line, measured from per-bit strobes. In address mode it is a character whose address/wake bit is set. In address mode that character is passed on as the first character of the new message, with its address flag set.

Software can force the receiver back into hunt mode at any time with a one-cycle command pulse. If a message was open when the command arrived, the block emits a one-cycle abort pulse, so the downstream buffer logic can close the current buffer with an error status. Line breaks reported while hunting are counted in a saturating counter and raise a sticky interrupt flag. That flag is cleared by a write-one-to-clear strobe.

Top module: `uart_hunt_ctrl`

## Requirements
- R1: After reset the block is hunting: `rx_en_o`=0, `out_valid_o`=0, `abort_o`=0, `brk_cnt_o`=0, `brk_irq_o`=0.
- R2: While hunting, no received character appears on `out_valid_o`, except the address character that ends hunt in address mode (R4).
- R3: With `mode_addr_i`=0, hunt ends after IDLE_BITS (default 10) consecutive bit strobes with `rx_line_i`=1. A strobe with the line at 0 restarts the count, and so does a hunt command. `rx_en_o` rises one cycle after the strobe that completes the count.
- R4: With `mode_addr_i`=1, idle time has no effect. A character with `char_addr_i`=1 received while hunting ends hunt and is delivered one cycle later with `out_addr_o`=1.
- R5: While enabled, each `char_valid_i` pulse produces `out_valid_o` one cycle later, carrying the same data and address flag.
- R6: A `hunt_cmd_i` pulse drops `rx_en_o` on the next cycle and discards any character offered in the same cycle. The command takes priority over every exit event.
- R7: A hunt command that arrives while the receiver is enabled, after at least one character has been delivered since the last hunt entry, produces a `abort_o` pulse exactly one cycle long on the next cycle. In every other case `abort_o` stays 0.
- R8: A `break_i` pulse while hunting increments `brk_cnt_o` and sets `brk_irq_o` one cycle later. A break while enabled changes neither.
- R9: `brk_cnt_o` saturates at 2^BRK_W-1 (0xFFFF by default).
- R10: `brk_cnt_clr_i` zeroes `brk_cnt_o` on the next cycle and wins over a simultaneous increment.
- R11: `brk_irq_o` stays set until `brk_irq_clr_i` is pulsed. A new break in the same cycle as the clear keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_addr_i | input | 1 | Resync select: 0 = idle time, 1 = address character |
| hunt_cmd_i | input | 1 | Enter-hunt command pulse |
| bit_tick_i | input | 1 | One pulse per received bit time |
| rx_line_i | input | 1 | Sampled line level, valid with `bit_tick_i` |
| char_valid_i | input | 1 | Deserialised character available |
| char_data_i | input | DATA_W | Character data |
| char_addr_i | input | 1 | Address/wake bit of the character |
| break_i | input | 1 | Break sequence detected |
| brk_cnt_clr_i | input | 1 | Synchronous break counter clear |
| brk_irq_clr_i | input | 1 | Write-one-to-clear for the break flag |
| rx_en_o | output | 1 | Receiver enabled (not hunting) |
| out_valid_o | output | 1 | Delivered character strobe |
| out_data_o | output | DATA_W | Delivered character data |
| out_addr_o | output | 1 | Delivered character is an address character |
| abort_o | output | 1 | Message abort pulse |
| brk_cnt_o | output | BRK_W | Break event count |
| brk_irq_o | output | 1 | Sticky break interrupt |

## Verification
The assertions assume that every input is a known value on each clock edge after reset, and that `char_addr_i` and `char_data_i` matter only in cycles where `char_valid_i` is high. They do not assume that events are exclusive: a command, a character, a break and a strobe may all arrive in the same cycle. The stimulus therefore draws every input independently from a seeded `$urandom`, so these collisions occur often. Directed phases add an exact idle count broken one strobe short, an address-mode exit, and a long run of breaks that drives the counter into saturation.

// File: rtl/uart_hunt_pkg.sv
package uart_hunt_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_RECV = 1'b1
  } hunt_st_e;

  typedef enum logic {
    RESYNC_IDLE = 1'b0,
    RESYNC_ADDR = 1'b1
  } resync_e;
endpackage

// File: rtl/uart_idle_det.sv
module uart_idle_det #(
  parameter int unsigned IDLE_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic bit_tick_i,
  input  logic rx_line_i,
  output logic idle_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(IDLE_BITS);

  logic [CNT_W-1:0] cnt_q;

  assign idle_o = bit_tick_i & rx_line_i & ~restart_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (bit_tick_i) begin
      if (!rx_line_i)        cnt_q <= '0;
      else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_IDLE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !idle_o || (cnt_q == '0 && IDLE_BITS == 1)) else $error("idle restart"); // R3
endmodule

// File: rtl/uart_brk_cnt.sv
module uart_brk_cnt #(
  parameter int unsigned BRK_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             cnt_clr_i,
  input  logic             irq_clr_i,
  output logic [BRK_W-1:0] cnt_o,
  output logic             irq_o
);
  localparam logic [BRK_W-1:0] CNT_MAX = {BRK_W{1'b1}};

  logic [BRK_W-1:0] cnt_q;
  logic             irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // a fresh event beats a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (inc_i)     irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !cnt_clr_i) |=> cnt_q == CNT_MAX) else $error("cnt sat"); // R9
  AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> cnt_q == '0) else $error("cnt clr"); // R10
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q) else $error("irq sticky"); // R11
  AST_INC_SETS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> irq_q) else $error("irq set"); // R8
endmodule

// File: rtl/uart_hunt_fsm.sv
module uart_hunt_fsm
  import uart_hunt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  resync_e           resync_i,
  input  logic              hunt_cmd_i,
  input  logic              idle_i,
  input  logic              char_valid_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              char_addr_i,
  input  logic              break_i,
  output logic              hunting_o,
  output logic              brk_inc_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_addr_o,
  output logic              abort_o
);
  hunt_st_e          st_q, st_d;
  logic              open_q;
  logic              valid_q, addr_q, abort_q;
  logic [DATA_W-1:0] data_q;
  logic              addr_hit, resync, deliver;

  assign addr_hit = char_valid_i & char_addr_i & (resync_i == RESYNC_ADDR);
  assign resync   = (resync_i == RESYNC_IDLE) ? idle_i : addr_hit;
  assign deliver  = char_valid_i & ~hunt_cmd_i & ((st_q == ST_RECV) | addr_hit);

  always_comb begin
    st_d = st_q;
    if (hunt_cmd_i)                    st_d = ST_HUNT;
    else if (st_q == ST_HUNT && resync) st_d = ST_RECV;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HUNT;
      open_q  <= 1'b0;
      valid_q <= 1'b0;
      addr_q  <= 1'b0;
      abort_q <= 1'b0;
      data_q  <= '0;
    end else begin
      st_q    <= st_d;
      valid_q <= deliver;
      abort_q <= hunt_cmd_i & (st_q == ST_RECV) & open_q;
      if (hunt_cmd_i)   open_q <= 1'b0;
      else if (deliver) open_q <= 1'b1;
      if (deliver) begin
        data_q <= char_data_i;
        addr_q <= char_addr_i;
      end
    end
  end

  assign hunting_o   = (st_q == ST_HUNT);
  assign brk_inc_o   = break_i & (st_q == ST_HUNT);
  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;
  assign out_addr_o  = addr_q & valid_q;
  assign abort_o     = abort_q;

  AST_NO_CHAR_HUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HUNT && !addr_hit) |=> !valid_q) else $error("char in hunt"); // R2
  AST_ADDR_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HUNT && addr_hit && !hunt_cmd_i) |=> (st_q == ST_RECV && valid_q && addr_q)) else $error("addr exit"); // R4
  AST_IDLE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HUNT && resync_i == RESYNC_IDLE && idle_i && !hunt_cmd_i) |=> st_q == ST_RECV) else $error("idle exit"); // R3
  AST_CMD_HUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_cmd_i |=> (st_q == ST_HUNT && !valid_q)) else $error("cmd hunt"); // R6
  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |=> !abort_q) else $error("abort width"); // R7
endmodule

// File: rtl/uart_hunt_ctrl.sv
module uart_hunt_ctrl
  import uart_hunt_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned IDLE_BITS = 10,
  parameter int unsigned BRK_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_addr_i,
  input  logic              hunt_cmd_i,
  input  logic              bit_tick_i,
  input  logic              rx_line_i,
  input  logic              char_valid_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              char_addr_i,
  input  logic              break_i,
  input  logic              brk_cnt_clr_i,
  input  logic              brk_irq_clr_i,
  output logic              rx_en_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_addr_o,
  output logic              abort_o,
  output logic [BRK_W-1:0]  brk_cnt_o,
  output logic              brk_irq_o
);
  logic    idle, hunting, brk_inc;
  resync_e resync;

  assign resync = mode_addr_i ? RESYNC_ADDR : RESYNC_IDLE;

  uart_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (hunt_cmd_i),
    .bit_tick_i (bit_tick_i),
    .rx_line_i  (rx_line_i),
    .idle_o     (idle)
  );

  uart_hunt_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .resync_i     (resync),
    .hunt_cmd_i   (hunt_cmd_i),
    .idle_i       (idle),
    .char_valid_i (char_valid_i),
    .char_data_i  (char_data_i),
    .char_addr_i  (char_addr_i),
    .break_i      (break_i),
    .hunting_o    (hunting),
    .brk_inc_o    (brk_inc),
    .out_valid_o  (out_valid_o),
    .out_data_o   (out_data_o),
    .out_addr_o   (out_addr_o),
    .abort_o      (abort_o)
  );

  uart_brk_cnt #(.BRK_W(BRK_W)) u_brk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (brk_inc),
    .cnt_clr_i (brk_cnt_clr_i),
    .irq_clr_i (brk_irq_clr_i),
    .cnt_o     (brk_cnt_o),
    .irq_o     (brk_irq_o)
  );

  assign rx_en_o = ~hunting;

  AST_BRK_ONLY_HUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_o && !brk_cnt_clr_i) |=> $stable(brk_cnt_o)) else $error("brk while enabled"); // R8
endmodule

// File: tb/tb_uart_hunt_ctrl.sv
module tb_uart_hunt_ctrl;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDLE_BITS = 10;
  localparam int unsigned BRK_W = 16;
  localparam logic [BRK_W-1:0] CMAX = {BRK_W{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode, cmd, tick, line, cv, ca, brk, cclr, iclr;
  logic [DATA_W-1:0] cd;
  logic rx_en, ov, oa, ab, irq;
  logic [DATA_W-1:0] od;
  logic [BRK_W-1:0] cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_hunt_ctrl #(.DATA_W(DATA_W), .IDLE_BITS(IDLE_BITS), .BRK_W(BRK_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_addr_i(mode), .hunt_cmd_i(cmd),
    .bit_tick_i(tick), .rx_line_i(line), .char_valid_i(cv), .char_data_i(cd),
    .char_addr_i(ca), .break_i(brk), .brk_cnt_clr_i(cclr), .brk_irq_clr_i(iclr),
    .rx_en_o(rx_en), .out_valid_o(ov), .out_data_o(od), .out_addr_o(oa),
    .abort_o(ab), .brk_cnt_o(cnt), .brk_irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;
  string req = "R2";

  // reference state
  bit m_hunt, m_open, m_valid, m_addr, m_abort, m_irq;
  logic [DATA_W-1:0] m_data;
  logic [BRK_W-1:0] m_cnt;
  int m_icnt;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [BRK_W-1:0] next_cnt(logic [BRK_W-1:0] c, bit inc, bit clr);
    if (clr) return '0;
    if (inc && c != CMAX) return c + 1'b1;
    return c;
  endfunction

  task automatic model_edge();
    bit idle, hit, dlv, inc;
    idle = tick && line && !cmd && (m_icnt == IDLE_BITS - 1);
    if (cmd) m_icnt = 0;
    else if (tick) m_icnt = !line ? 0 : (m_icnt < IDLE_BITS ? m_icnt + 1 : m_icnt);
    hit = cv && ca && mode;
    dlv = cv && !cmd && (!m_hunt || hit);
    inc = brk && m_hunt;
    m_abort = cmd && !m_hunt && m_open;
    m_valid = dlv;
    if (dlv) begin m_data = cd; m_addr = ca; end
    m_cnt = next_cnt(m_cnt, inc, cclr);
    if (inc) m_irq = 1; else if (iclr) m_irq = 0;
    if (cmd) m_open = 0; else if (dlv) m_open = 1;
    if (cmd) m_hunt = 1;
    else if (m_hunt && (mode ? hit : idle)) m_hunt = 0;
  endtask

  task automatic compare();
    chk(req, rx_en, !m_hunt);
    chk(req, ov, m_valid);
    if (m_valid) begin
      chk("R5", od, m_data);
      chk("R5", oa, m_addr);
    end
    chk("R7", ab, m_abort);
    chk("R8", cnt, m_cnt);
    chk("R11", irq, m_irq);
  endtask

  // inputs already driven; clock one edge, then compare at the falling edge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle_in();
    cmd = 0; tick = 0; line = 1; cv = 0; ca = 0; brk = 0; cclr = 0; iclr = 0; cd = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    mode = 0; idle_in();
    m_hunt = 1; m_open = 0; m_valid = 0; m_addr = 0; m_abort = 0; m_irq = 0;
    m_data = '0; m_cnt = '0; m_icnt = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", rx_en, 0); chk("R1", ov, 0); chk("R1", ab, 0);
    chk("R1", cnt, 0); chk("R1", irq, 0);
    rst_n = 1;
    @(negedge clk);

    // R3: idle count broken one strobe short, then completed
    req = "R3";
    mode = 0;
    for (int i = 0; i < IDLE_BITS - 1; i++) begin tick = 1; line = 1; step(); end
    tick = 1; line = 0; step();
    chk("R3", rx_en, 0);
    for (int i = 0; i < IDLE_BITS; i++) begin tick = 1; line = 1; step(); end
    chk("R3", rx_en, 1);
    tick = 0;

    // R5 + R7: deliver, then command aborts the open message
    req = "R5";
    cv = 1; cd = 8'hA5; ca = 0; step(); cv = 0;
    chk("R5", od, 8'hA5);
    req = "R6";
    cmd = 1; cv = 1; cd = 8'h3C; step(); cmd = 0; cv = 0;
    chk("R6", rx_en, 0); chk("R6", ov, 0); chk("R7", ab, 1);
    step(); chk("R7", ab, 0);

    // R8: breaks while hunting; R2: chars dropped while hunting
    req = "R2";
    brk = 1; cv = 1; ca = 0; step(); brk = 0; cv = 0;
    chk("R8", cnt, 1); chk("R8", irq, 1); chk("R2", ov, 0);

    // R4: address mode ignores idle and exits on an address char
    req = "R4"; mode = 1;
    for (int i = 0; i < IDLE_BITS + 2; i++) begin tick = 1; line = 1; step(); end
    tick = 0; chk("R4", rx_en, 0);
    cv = 1; ca = 1; cd = 8'h7E; step(); cv = 0; ca = 0;
    chk("R4", rx_en, 1); chk("R4", ov, 1); chk("R4", oa, 1);

    // R11: clear vs simultaneous break, then plain clear
    cmd = 1; step(); cmd = 0;
    brk = 1; iclr = 1; step(); chk("R11", irq, 1);
    brk = 0; step(); chk("R11", irq, 0); iclr = 0;

    // R10: clear beats increment
    brk = 1; cclr = 1; step(); chk("R10", cnt, 0); cclr = 0;

    // R9: saturate (still hunting in address mode, no chars)
    req = "R9";
    for (int i = 0; i < (1 << BRK_W) + 4; i++) step();
    chk("R9", cnt, CMAX);
    brk = 0; step(); chk("R9", cnt, CMAX);
    cclr = 1; step(); cclr = 0;

    // random mix
    req = "R6";
    for (int i = 0; i < 20000; i++) begin
      cmd  = ($urandom % 40) == 0;
      tick = ($urandom % 2) == 0;
      line = ($urandom % 12) != 0;
      cv   = ($urandom % 4) == 0;
      ca   = ($urandom % 3) == 0;
      cd   = DATA_W'($urandom);
      brk  = ($urandom % 16) == 0;
      cclr = ($urandom % 200) == 0;
      iclr = ($urandom % 30) == 0;
      if (($urandom % 500) == 0) mode = ~mode;
      step();
    end
    idle_in(); step();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule